// File: doc/BRIEF.md
# Start-Bit Framed Serial Converter Port

This block is the digital serial front end of an 8-bit sampling converter. A host drives a select line, a serial clock and a serial data line. The port does not treat the select edge as the start of a frame. It waits for the first logic 1 on serial data in while the select line is low, and treats that 1 as the leading bit of an 8-bit control byte. The converter's sampled value comes in on a parallel bus, which stands in for the analog part. Once the control byte is complete, the port latches that value and shifts it back to the host most significant bit first.

The port is built for back-to-back conversions. Once the result MSB is on the line, hunting for the next start bit resumes while the rest of the result is still shifting out. A new control byte can therefore overlap the tail of the previous result. When the select line is raised, all framing state is dropped and any result in flight is abandoned. The completed control byte is presented in parallel together with a one-cycle pulse that marks the start of each conversion.

All pins are sampled on the system clock `clk`. Serial-clock edges are found by comparing each sample with the one before it.

Top module: `sbadc_port`

## Requirements
- R1: A falling edge on `cs_n` alone starts nothing. Zeros on `sdi` while the port is hunting for a start bit are ignored, so `conv_valid` stays 0.
- R2: With `cs_n` low and the port hunting, the first `sdi` = 1 sampled on a rising `sclk` edge is the start bit. It becomes bit 7 of `ctrl_byte`, and the following seven bits fill bits 6 down to 0 in arrival order.
- R3: A conversion begins on the `sclk` falling edge after the eighth control bit is sampled. `conv_valid` is high for exactly one `clk` cycle, and `ctrl_byte` presents the new byte in that same cycle. `ctrl_byte` changes at no other time.
- R4: `sample_val` is captured when the conversion begins. `sdo` shows bit 7 of the captured value after the next `sclk` falling edge, then bits 6 down to 0 on the following seven falling edges. After bit 0, `sdo` returns to 0.
- R5: A 1 on `sdi` sampled after a conversion begins but before its MSB is driven is not taken as a start bit.
- R6: Once the result MSB has been driven, a new start bit is accepted while the remaining result bits still shift out. A new conversion that begins during shifting restarts the result with the new sample.
- R7: A rising edge on `cs_n` abandons any partial control byte and any result being shifted, clears the bit count and sets `sdo` to 0. The next frame needs a full eight control bits.
- R8: `sdo_oe` is 1 exactly while `cs_n` is low, which models a high-impedance output whenever the port is deselected.
- R9: `sdi` is sampled only on rising `sclk` edges. `sdo` changes only after a falling `sclk` edge or a rising `cs_n` edge.
- R10: After reset, `conv_valid` = 0, `ctrl_byte` = 0 and `sdo` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (control byte) |
| sample_val | input | DATA_W | Sampled value standing in for the converter output |
| sdo | output | 1 | Serial result out, MSB first |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| conv_valid | output | 1 | One-cycle pulse when a conversion begins |
| ctrl_byte | output | CTRL_W | Last completed control byte |

## Verification
The hardest situation to reach from the pins is the overlap: a new control byte arriving while the previous result is still shifting out, and the one-edge window just before the MSB in which a 1 must be ignored. To reach the overlap, the stimulus sends the first bit of the next control byte on the rising edge right after the MSB appears. It then checks that the old result bits and the new byte interleave correctly and that the new conversion lands on the ninth edge. To probe the window, it puts a 1 on the rising edge just before the MSB fall and confirms that no conversion follows eight edges later.

// File: rtl/sbadc_pkg.sv
package sbadc_pkg;
  typedef enum logic [1:0] {
    RX_HUNT    = 2'd0,
    RX_COLLECT = 2'd1,
    RX_PEND    = 2'd2
  } rx_st_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_st_t;
endpackage

// File: rtl/sbadc_edge.sv
module sbadc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sck_rise,
  output logic sck_fall,
  output logic desel
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  // serial clock edges only count while selected
  assign sck_rise = sclk & ~sclk_q & ~cs_n;
  assign sck_fall = ~sclk & sclk_q & ~cs_n;
  assign desel    = cs_n & ~cs_q;
endmodule

// File: rtl/sbadc_rx.sv
module sbadc_rx
  import sbadc_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              desel,
  input  logic              sdi,
  input  logic              hunt_ok,
  output logic              launch,
  output logic              conv_valid,
  output logic [CTRL_W-1:0] ctrl_byte
);
  localparam int CW = $clog2(CTRL_W + 1);
  localparam logic [CW-1:0] LAST = CW'(CTRL_W - 1);

  rx_st_t            st_q, st_d;
  logic [CTRL_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              cv_q;

  assign launch = (st_q == RX_PEND) && sck_fall;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    if (desel) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        RX_HUNT: if (sck_rise && sdi && hunt_ok) begin
          sh_d  = CTRL_W'(1);
          cnt_d = CW'(1);
          st_d  = RX_COLLECT;
        end
        RX_COLLECT: if (sck_rise) begin
          sh_d  = {sh_q[CTRL_W-2:0], sdi};
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == LAST) st_d = RX_PEND;
        end
        RX_PEND: if (sck_fall) begin
          ctrl_d = sh_q;
          cnt_d  = '0;
          st_d   = RX_HUNT;
        end
        default: st_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      sh_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      cv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      cv_q   <= launch;
    end
  end

  assign conv_valid = cv_q;
  assign ctrl_byte  = ctrl_q;
endmodule

// File: rtl/sbadc_tx.sv
module sbadc_tx
  import sbadc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              desel,
  input  logic              launch,
  input  logic [DATA_W-1:0] sample_val,
  output logic              hunt_ok,
  output logic              sdo
);
  localparam int LW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_st_t            st_q, st_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [LW-1:0]     left_q, left_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    st_d   = st_q;
    res_d  = res_q;
    left_d = left_q;
    sdo_d  = sdo_q;
    if (desel) begin
      st_d  = TX_IDLE;
      sdo_d = 1'b0;
    end else if (launch) begin
      res_d = sample_val;
      sdo_d = 1'b0;
      st_d  = TX_WAIT;
    end else if (sck_fall) begin
      unique case (st_q)
        TX_WAIT: begin
          sdo_d  = res_q[DATA_W-1];
          res_d  = res_q << 1;
          left_d = LW'(DATA_W - 1);
          st_d   = TX_SHIFT;
        end
        TX_SHIFT: begin
          if (left_q != '0) begin
            sdo_d  = res_q[DATA_W-1];
            res_d  = res_q << 1;
            left_d = left_q - LW'(1);
          end else begin
            sdo_d = 1'b0;
            st_d  = TX_IDLE;
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      res_q  <= '0;
      left_q <= '0;
      sdo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      left_q <= left_d;
      sdo_q  <= sdo_d;
    end
  end

  // start bits stay blocked until the MSB has left
  assign hunt_ok = (st_q != TX_WAIT);
  assign sdo     = sdo_q;
endmodule

// File: rtl/sbadc_port.sv
module sbadc_port #(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_val,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              conv_valid,
  output logic [CTRL_W-1:0] ctrl_byte
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sck_rise, sck_fall, desel, launch, hunt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sbadc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .desel    (desel)
  );

  sbadc_rx #(.CTRL_W(CTRL_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .desel      (desel),
    .sdi        (sdi),
    .hunt_ok    (hunt_ok),
    .launch     (launch),
    .conv_valid (conv_valid),
    .ctrl_byte  (ctrl_byte)
  );

  sbadc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sck_fall   (sck_fall),
    .desel      (desel),
    .launch     (launch),
    .sample_val (sample_val),
    .hunt_ok    (hunt_ok),
    .sdo        (sdo)
  );

  assign sdo_oe = ~cs_n;
endmodule

// File: rtl/sbadc_chk.sv
module sbadc_chk #(
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              sdo,
  input logic              conv_valid,
  input logic [CTRL_W-1:0] ctrl_byte
);
  // R3
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> !conv_valid);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |-> $stable(ctrl_byte));

  // R2
  start_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> ctrl_byte[CTRL_W-1]);

  // R3
  conv_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (!$past(sclk) && $past(sclk, 2)));

  // R9
  sdo_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ((!$past(sclk) && $past(sclk, 2)) || $past(cs_n)));

  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !sdo);
endmodule

bind sbadc_port sbadc_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .sdo        (sdo),
  .conv_valid (conv_valid),
  .ctrl_byte  (ctrl_byte)
);

// File: tb/sbadc_port_tb.sv
module sbadc_port_tb;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, sdi;
  logic [7:0] sample_val;
  logic       sdo, sdo_oe, conv_valid;
  logic [7:0] ctrl_byte;
  int         nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  sbadc_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sample_val(sample_val), .sdo(sdo), .sdo_oe(sdo_oe),
    .conv_valid(conv_valid), .ctrl_byte(ctrl_byte)
  );

  // lead zeros [19:16], control byte [15:8] (bit7 = start), sample [7:0]
  localparam logic [19:0] VEC [0:5] = '{
    {4'd0, 8'h80, 8'hA5}, {4'd3, 8'hFF, 8'h00}, {4'd1, 8'h9C, 8'hFF},
    {4'd5, 8'hC3, 8'h5A}, {4'd2, 8'hB1, 8'h01}, {4'd7, 8'hE6, 8'h80}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sclk period: rise with din, then fall; sample outputs just after the fall
  task automatic tick(input logic din, output logic cv, output logic [7:0] cb, output logic dout);
    sdi  = din;
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
    wait_clk(1);
    cv   = conv_valid;
    cb   = ctrl_byte;
    dout = sdo;
    wait_clk(3);
  endtask

  task automatic desel_pulse();
    cs_n = 1'b1;
    wait_clk(2);
    chk(sdo == 1'b0, "R7 sdo cleared on deselect", {7'd0, sdo}, 8'h00);
    chk(sdo_oe == 1'b0, "R8 oe low while deselected", {7'd0, sdo_oe}, 8'h00);
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  // sends a control byte; cv checked low before last bit, high on last
  task automatic send_ctrl(input logic [7:0] c, input string req);
    logic cv, d;
    logic [7:0] cb;
    for (int b = 7; b >= 0; b--) begin
      tick(c[b], cv, cb, d);
      if (b != 0) chk(cv == 1'b0, {req, " no early conversion"}, {7'd0, cv}, 8'h00);
      else begin
        chk(cv == 1'b1, {req, " conv_valid on eighth fall (R3)"}, {7'd0, cv}, 8'h01);
        chk(cb == c, {req, " ctrl_byte (R2)"}, cb, c);
      end
    end
  endtask

  task automatic read_result(output logic [7:0] r);
    logic cv, d;
    logic [7:0] cb;
    for (int b = 7; b >= 0; b--) begin
      tick(1'b0, cv, cb, d);
      r[b] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic cv, d;
    logic [7:0] cb, r;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; sample_val = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R10 reset state
    chk(conv_valid == 1'b0, "R10 conv_valid after reset", {7'd0, conv_valid}, 8'h00);
    chk(ctrl_byte == 8'h00, "R10 ctrl_byte after reset", ctrl_byte, 8'h00);
    chk(sdo == 1'b0, "R10 sdo after reset", {7'd0, sdo}, 8'h00);
    chk(sdo_oe == 1'b0, "R8 oe low after reset with cs_n high", {7'd0, sdo_oe}, 8'h00);

    // R1: select falls, only zeros follow
    cs_n = 1'b0;
    wait_clk(4);
    chk(sdo_oe == 1'b1, "R8 oe high while selected", {7'd0, sdo_oe}, 8'h01);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, cv, cb, d);
      chk(cv == 1'b0, "R1 zeros and cs fall start nothing", {7'd0, cv}, 8'h00);
    end
    cs_n = 1'b1;
    wait_clk(4);

    // vector table
    foreach (VEC[i]) begin
      sample_val = VEC[i][7:0];
      cs_n = 1'b0;
      wait_clk(4);
      for (int z = 0; z < int'(VEC[i][19:16]); z++) begin
        tick(1'b0, cv, cb, d);
        chk(cv == 1'b0, "R1 leading zeros ignored", {7'd0, cv}, 8'h00);
      end
      send_ctrl(VEC[i][15:8], "R2");
      sample_val = ~VEC[i][7:0];
      read_result(r);
      chk(r == VEC[i][7:0], "R4 result MSB first, sample captured at start", r, VEC[i][7:0]);
      tick(1'b0, cv, cb, d);
      chk(d == 1'b0, "R4 sdo returns to 0 after bit 0", {7'd0, d}, 8'h00);
      cs_n = 1'b1;
      wait_clk(4);
    end

    // R5: a 1 just before the MSB fall must not start a frame
    sample_val = 8'h3C;
    cs_n = 1'b0;
    wait_clk(4);
    send_ctrl(8'h8F, "R5 setup");
    r = '0;
    for (int t = 0; t < 12; t++) begin
      tick(t == 0, cv, cb, d);
      if (t < 8) r[7-t] = d;
      chk(cv == 1'b0, "R5 start bit before MSB ignored", {7'd0, cv}, 8'h00);
    end
    chk(r == 8'h3C, "R5 result intact", r, 8'h3C);
    cs_n = 1'b1;
    wait_clk(4);

    // R6: next control byte overlaps result shifting
    sample_val = 8'hC9;
    cs_n = 1'b0;
    wait_clk(4);
    send_ctrl(8'hA2, "R6 first");
    tick(1'b0, cv, cb, d);
    r = '0;
    r[7] = d;
    for (int b = 7; b >= 0; b--) begin
      if (b == 0) sample_val = 8'h36;
      tick(8'hD4 >> b, cv, cb, d);
      if (b != 0) begin
        r[b-1] = d;
        chk(cv == 1'b0, "R6 no early conversion", {7'd0, cv}, 8'h00);
      end else begin
        chk(cv == 1'b1, "R6 overlapped conversion starts", {7'd0, cv}, 8'h01);
        chk(cb == 8'hD4, "R6 overlapped ctrl_byte", cb, 8'hD4);
      end
    end
    chk(r == 8'hC9, "R6 old result while new byte arrives", r, 8'hC9);
    sample_val = 8'h00;
    read_result(r);
    chk(r == 8'h36, "R6 new result", r, 8'h36);
    cs_n = 1'b1;
    wait_clk(4);

    // R7: partial control byte dropped
    cs_n = 1'b0;
    wait_clk(4);
    tick(1'b1, cv, cb, d); tick(1'b0, cv, cb, d);
    tick(1'b1, cv, cb, d); tick(1'b1, cv, cb, d);
    desel_pulse();
    send_ctrl(8'h81, "R7 fresh frame after abort");

    // R7: abort mid-result
    cs_n = 1'b1;
    wait_clk(4);
    sample_val = 8'hFF;
    cs_n = 1'b0;
    wait_clk(4);
    send_ctrl(8'hF0, "R7 setup");
    for (int t = 0; t < 3; t++) begin
      tick(1'b0, cv, cb, d);
      chk(d == 1'b1, "R7 bits before abort", {7'd0, d}, 8'h01);
    end
    desel_pulse();
    for (int t = 0; t < 8; t++) begin
      tick(1'b0, cv, cb, d);
      chk(d == 1'b0 && cv == 1'b0, "R7 shifting stopped after abort", {6'd0, cv, d}, 8'h00);
    end
    chk(ctrl_byte == 8'hF0, "R3 ctrl_byte held between conversions", ctrl_byte, 8'hF0);
    cs_n = 1'b1;
    wait_clk(4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule